// File: doc/BRIEF.md
# Spare-Lane Bit Steering Datapath

This block sits between the ECC encoder/decoder of a memory controller and the 144-bit data path of one memory port. The codeword is 140 bits wide: 128 data bits and a 12-bit check code. It is treated as 35 device lanes of 4 bits each, plus one 4-bit spare lane in the physical beat. When background scrubbing reports a failed x4 device lane, the block steers it. Writes copy that lane's bits into the spare lane, and reads put the spare bits back in place of the failed lane. The ECC decoder therefore always sees the codeword that was written, with no help from software.

Repeated device failures on the port are escalated in stages, driven by a saturating 2-bit fault counter:
- The first failure is absorbed by steering and only produces a log pulse.
- The second failure, which chip-level correction must absorb, raises the operator alert.
- The third failure raises the alert again and, when mirroring is enabled, takes the module offline.

A high-performance configuration input bypasses steering completely.

Both steering paths are combinational and add no latency. The lane-select register is only reloaded on a cycle with no transaction in flight, so a beat never sees the steering change halfway through.

Top module: `spare_lane_steer`

## Requirements
- R1: After reset the fault count is 0, log, alert and offline are low and no lane is steered. With no lane steered, the spare lane bits [143:140] of the written beat are 0 and the read codeword equals the read beat bits [139:0].
- R2: Codeword lane i (bits 4i+3..4i, i = 0..34) is always written to physical bits 4i+3..4i. With no steering, each read lane is taken from the same position.
- R3: With lane L steered, the written spare lane equals codeword lane L. The read codeword takes lane L from the spare lane, and every other lane from its own position. Both paths are combinational.
- R4: A fault report that finds the count at 0, with performance mode off, gives the following in the cycle after the capturing edge: a one-cycle log pulse, no alert, count 1, and the reported lane armed for steering.
- R5: An armed lane loads into the lane-select register only at an edge where busy is low. Steering does not change while busy is high.
- R6: A fault that finds the count at 1 gives a one-cycle alert pulse and count 2, and leaves the steered lane unchanged.
- R7: A fault that finds the count at 2 gives an alert pulse and count 3. It sets offline if and only if mirror enable is high. Offline stays set until reset.
- R8: Further faults at count 3 each give an alert pulse, and the count stays at 3.
- R9: A fault report with a lane index of 35 or above has no effect on the count, the pulses or the steering.
- R10: In performance mode the written spare lane is 0 and reads pass through unsteered. A first fault then raises alert instead of log and arms no steering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| perf_mode | input | 1 | High-performance mode, steering bypassed |
| mirror_en | input | 1 | Mirroring enabled, third fault takes the module offline |
| busy | input | 1 | A transaction is in flight |
| fault_valid | input | 1 | Scrubber reports a failed device lane |
| fault_lane | input | 6 | Index of the failed lane |
| wr_cw | input | 140 | Codeword from the ECC encoder |
| wr_phy | output | 144 | Beat driven to memory |
| rd_phy | input | 144 | Beat read from memory |
| rd_cw | output | 140 | Codeword to the ECC decoder |
| steer_valid | output | 1 | A lane is steered |
| steer_lane | output | 6 | Steered lane index |
| fault_count | output | 2 | Saturating count of device failures |
| log_evt | output | 1 | One-cycle log event pulse |
| alert | output | 1 | One-cycle operator alert pulse |
| offline | output | 1 | Module taken offline |

## Verification
The datapath results are combinational, so each read is checked in the same cycle its beat is driven. The monitor compares at the falling edge, against the codeword the driver queued. A fault report captured at one rising edge changes the count and the pulses in the cycle after that edge, and the pulses are checked low again one cycle later. Steering appears one edge after the capture at the earliest, because the armed lane loads at the next edge where busy is low. The bench holds busy high across that edge to show the deferral, then samples one cycle after releasing it.

// File: rtl/spare_lane_steer.sv
module spare_lane_steer #(
  parameter int LANE_W = 4,
  parameter int DATA_W = 128,
  parameter int CHK_W  = 12,
  parameter int CW_W   = DATA_W + CHK_W,
  parameter int PHY_W  = CW_W + LANE_W,
  parameter int IDX_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             perf_mode,
  input  logic             mirror_en,
  input  logic             busy,
  input  logic             fault_valid,
  input  logic [IDX_W-1:0] fault_lane,
  input  logic [CW_W-1:0]  wr_cw,
  output logic [PHY_W-1:0] wr_phy,
  input  logic [PHY_W-1:0] rd_phy,
  output logic [CW_W-1:0]  rd_cw,
  output logic             steer_valid,
  output logic [IDX_W-1:0] steer_lane,
  output logic [1:0]       fault_count,
  output logic             log_evt,
  output logic             alert,
  output logic             offline
);
  localparam int NLANES = CW_W / LANE_W;

  logic             steer_on;
  logic [LANE_W-1:0] wr_sel;
  logic             pend;
  logic [IDX_W-1:0] pend_lane;
  logic             fault_ok;

  assign steer_on = steer_valid & ~perf_mode;
  assign fault_ok = fault_valid && (fault_lane < IDX_W'(NLANES));

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    assign wr_phy[i*LANE_W +: LANE_W] = wr_cw[i*LANE_W +: LANE_W];
    assign rd_cw[i*LANE_W +: LANE_W] =
      (steer_on && steer_lane == IDX_W'(i)) ? rd_phy[CW_W +: LANE_W]
                                            : rd_phy[i*LANE_W +: LANE_W];
  end

  always_comb begin
    wr_sel = '0;
    for (int i = 0; i < NLANES; i++)
      if (steer_lane == IDX_W'(i)) wr_sel = wr_cw[i*LANE_W +: LANE_W];
  end

  assign wr_phy[CW_W +: LANE_W] = steer_on ? wr_sel : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_count <= '0;
      log_evt     <= 1'b0;
      alert       <= 1'b0;
      offline     <= 1'b0;
      pend        <= 1'b0;
      pend_lane   <= '0;
    end else begin
      log_evt <= 1'b0;
      alert   <= 1'b0;
      if (fault_ok) begin
        if (fault_count != 2'd3) fault_count <= fault_count + 2'd1;
        if (fault_count == 2'd0 && !perf_mode) begin
          log_evt   <= 1'b1;
          pend      <= 1'b1;
          pend_lane <= fault_lane;
        end else begin
          alert <= 1'b1;
        end
        if (fault_count == 2'd2 && mirror_en) offline <= 1'b1;
      end
      if (pend && !busy) pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steer_valid <= 1'b0;
      steer_lane  <= '0;
    end else if (pend && !busy) begin
      steer_valid <= 1'b1;
      steer_lane  <= pend_lane;
    end
  end

  a_r5_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(steer_valid) && $stable(steer_lane)));

  a_r3_lane_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    steer_valid |-> (steer_lane < IDX_W'(NLANES)));

  a_r8_count_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fault_count >= $past(fault_count)));

  a_r9_count_needs_report: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |=> $stable(fault_count));

  a_r4_log_excludes_alert: assert property (@(posedge clk) disable iff (!rst_n)
    !(log_evt && alert));

  a_r7_offline_needs_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(offline) |-> $past(mirror_en));

  a_r7_offline_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    offline |=> offline);

  a_r10_perf_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    perf_mode |-> (wr_phy[CW_W +: LANE_W] == '0));
endmodule

// File: tb/spare_lane_steer_bench.sv
`timescale 1ns/1ps
module spare_lane_steer_bench;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         perf_mode = 0, mirror_en = 0, busy = 0, fault_valid = 0;
  logic [5:0]   fault_lane = 0;
  logic [139:0] wr_cw = 0;
  logic [143:0] wr_phy, rd_phy = 0;
  logic [139:0] rd_cw;
  logic         steer_valid;
  logic [5:0]   steer_lane;
  logic [1:0]   fault_count;
  logic         log_evt, alert, offline;

  int n_chk = 0, n_fail = 0;
  int stuck = -1;
  logic rd_req = 0;
  string rd_tag = "";
  logic [143:0] mem [8];
  logic [139:0] expq [$];

  always #10 clk = ~clk;

  spare_lane_steer u_spare_lane_steer (
    .clk(clk), .rst_n(rst_n), .perf_mode(perf_mode), .mirror_en(mirror_en),
    .busy(busy), .fault_valid(fault_valid), .fault_lane(fault_lane),
    .wr_cw(wr_cw), .wr_phy(wr_phy), .rd_phy(rd_phy), .rd_cw(rd_cw),
    .steer_valid(steer_valid), .steer_lane(steer_lane),
    .fault_count(fault_count), .log_evt(log_evt), .alert(alert), .offline(offline));

  task automatic chk(string req, logic [159:0] act, logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rd_req) begin
    logic [139:0] e;
    e = expq.pop_front();
    chk(rd_tag, 160'(rd_cw), 160'(e));
  end

  function automatic logic [139:0] pat(int seed);
    logic [159:0] t;
    t = {32'(seed) * 32'h9E3779B1, ~32'(seed), 32'h0F0F_1234 ^ 32'(seed),
         32'(seed) << 3, 32'hA5A5_5A5A + 32'(seed)};
    return t[139:0];
  endfunction

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;
  endtask

  task automatic do_write(int a, logic [139:0] cw, string req, logic [3:0] exp_spare);
    @(posedge clk); #1 wr_cw = cw; busy = 1;
    @(negedge clk);
    mem[a] = wr_phy;
    chk({req, " spare lane"}, 160'(wr_phy[143:140]), 160'(exp_spare));
    chk("R2 lane positions", 160'(wr_phy[139:0]), 160'(cw));
    @(posedge clk); #1 busy = 0;
  endtask

  task automatic do_read(int a, logic [139:0] exp, string req);
    logic [143:0] p;
    p = mem[a];
    if (stuck >= 0) p[stuck*4 +: 4] = ~p[stuck*4 +: 4];
    @(posedge clk); #1 rd_phy = p; busy = 1; rd_req = 1; rd_tag = req;
    expq.push_back(exp);
    @(posedge clk); #1 rd_req = 0; busy = 0;
  endtask

  task automatic do_fault(int lane);
    @(posedge clk); #1 fault_valid = 1; fault_lane = 6'(lane);
    @(posedge clk); #1 fault_valid = 0;
  endtask

  task automatic run_first(int lane);
    logic [139:0] cw;
    do_reset();
    stuck = -1;
    busy = 1;
    do_fault(lane);
    @(negedge clk);
    chk("R4 count after first", 160'(fault_count), 160'(1));
    chk("R4 log pulse", 160'(log_evt), 160'(1));
    chk("R4 no alert", 160'(alert), 160'(0));
    @(negedge clk);
    chk("R4 log one cycle", 160'(log_evt), 160'(0));
    chk("R5 held while busy", 160'(steer_valid), 160'(0));
    busy = 0;
    @(negedge clk);
    chk("R5 loaded when idle", 160'({steer_valid, steer_lane}), 160'({1'b1, 6'(lane)}));
    stuck = lane;
    for (int k = 0; k < 3; k++) begin
      cw = pat(lane * 7 + k);
      do_write(k, cw, "R3", cw[lane*4 +: 4]);
      do_read(k, cw, "R3 steered read intact");
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [139:0] cw;
    do_reset();
    @(negedge clk);
    chk("R1 reset count", 160'(fault_count), 160'(0));
    chk("R1 reset outputs", 160'({log_evt, alert, offline, steer_valid}), 160'(0));
    cw = pat(1);
    do_write(0, cw, "R1", 4'h0);
    do_read(0, cw, "R2 passthrough read");
    cw = pat(2);
    do_write(1, cw, "R1", 4'h0);
    do_read(1, cw, "R1 passthrough read");

    run_first(7);

    do_fault(35);
    @(negedge clk);
    chk("R9 bad lane count", 160'(fault_count), 160'(1));
    chk("R9 bad lane pulses", 160'({log_evt, alert}), 160'(0));
    chk("R9 bad lane steering", 160'(steer_lane), 160'(7));

    do_fault(12);
    @(negedge clk);
    chk("R6 second count", 160'(fault_count), 160'(2));
    chk("R6 second alert", 160'({alert, log_evt}), 160'(2'b10));
    @(negedge clk);
    chk("R6 alert one cycle", 160'(alert), 160'(0));
    chk("R6 lane kept", 160'({steer_valid, steer_lane}), 160'({1'b1, 6'd7}));
    do_read(2, pat(7*7+2), "R6 read still intact");

    perf_mode = 1;
    cw = pat(9);
    do_write(3, cw, "R10", 4'h0);
    do_read(3, cw ^ (140'hF << 28), "R10 perf read raw");
    perf_mode = 0;

    mirror_en = 1;
    do_fault(20);
    @(negedge clk);
    chk("R7 third count", 160'(fault_count), 160'(3));
    chk("R7 third alert", 160'(alert), 160'(1));
    chk("R7 offline set", 160'(offline), 160'(1));
    do_fault(21);
    @(negedge clk);
    chk("R8 saturate", 160'(fault_count), 160'(3));
    chk("R8 alert again", 160'(alert), 160'(1));
    chk("R7 offline sticky", 160'(offline), 160'(1));
    mirror_en = 0;
    do_reset();
    @(negedge clk);
    chk("R7 offline cleared by reset", 160'(offline), 160'(0));

    run_first(0);
    run_first(34);

    do_reset();
    mirror_en = 0;
    for (int k = 0; k < 3; k++) do_fault(k + 1);
    @(negedge clk);
    chk("R7 no mirror count", 160'(fault_count), 160'(3));
    chk("R7 no mirror no offline", 160'(offline), 160'(0));

    do_reset();
    perf_mode = 1;
    do_fault(3);
    @(negedge clk);
    chk("R10 perf first alert", 160'({alert, log_evt}), 160'(2'b10));
    chk("R10 perf count", 160'(fault_count), 160'(1));
    repeat (2) @(negedge clk);
    chk("R10 perf no steering", 160'(steer_valid), 160'(0));
    perf_mode = 0;

    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule